// File: doc/BRIEF.md
# PCIe Configuration Access Register Unit

This block turns host register writes into PCIe configuration reads and writes. Software loads a target address (bus, device, function and dword offset) into one register, places write data in a data register, and writes a control word. The control word sets the start bit, the header type, the access size and the direction. The unit then either sends one request on a simple internal request/response port, or it serves the access from a local configuration space array.

An access aimed at device 0 on the root bus never leaves the block. It reads or writes the local array, with the same byte-lane handling as an external access. The unit tracks the root bus number. A write to the primary-bus-number byte of the local space updates it, and requests to any other bus are refused until that byte has been written. Failures set sticky flags in an error register that software clears by writing ones. A read that fails returns all ones.

Top module: `cfg_access_unit`

## Requirements
- R1: After reset, all four registers (address 0, control 1, data 2, error 3; word index on `reg_addr_i`) read 0 and `req_valid_o` is low.
- R2: The address register holds bus in 31:24, device in 23:19, function in 18:16 and the byte offset in 11:0. An external request carries these bits on `req_addr_o` with bits 1:0 forced to 0, control bit 8 on `req_type1_o` (1 = type 1) and control bit 0 on `req_write_o` (1 = write).
- R3: A control write with bit 31 set starts an access. An external request holds `req_valid_o` and its fields until `req_ready_i`, and then drops. Control bit 16 reads 1 from the start until `resp_valid_i`. Control writes while busy are ignored.
- R4: A root-bus access with a device number other than 0 sets error bit 0 and issues no request.
- R5: A root-bus access to device 0 reads or writes the local array and issues no request. Dword indices at or above the array depth read 0, and writes to them are dropped.
- R6: A write that covers byte 0 of local dword 6 sets the root bus number to that byte. Until then, the root bus is 0 and an access to any other bus sets error bit 0 with no request.
- R7: Control bits 5:4 select the size (0 byte, 1 halfword, 2 word). Byte lanes are the size's lanes shifted by offset bits 1:0 and appear on `req_be_o`. Write data is taken from the low bits of the data register and shifted to those lanes. Read data is returned right-justified and zero-extended.
- R8: A halfword at an odd offset, a word at a non-multiple-of-4 offset, or size 3 sets error bit 1 and issues no request.
- R9: A response with `resp_ur_i` set sets error bit 4.
- R10: Writing the error register clears each flag whose bit is written as 1. Bits written as 0 leave their flags unchanged.
- R11: Register reads are registered: `reg_rdata_o` shows the selected register in the cycle after `reg_re_i`.
- R12: Control readback shows enable (31), type (8), size (5:4) and direction (0) as last accepted. Writing 0 clears them all.
- R13: A read access that fails through R4, R6, R8 or R9 leaves all ones in the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe, one cycle |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| req_valid_o | output | 1 | External request pending |
| req_ready_i | input | 1 | Completer accepts the request |
| req_addr_o | output | 32 | Packed bus/device/function/dword offset |
| req_be_o | output | 4 | Byte enables |
| req_wdata_o | output | 32 | Lane-placed write data |
| req_write_o | output | 1 | 1 = configuration write |
| req_type1_o | output | 1 | 1 = type 1, 0 = type 0 |
| resp_valid_i | input | 1 | Completion strobe |
| resp_ur_i | input | 1 | Completion is unsupported request |
| resp_rdata_i | input | 32 | Completion data dword |

## Verification
The bench uses the default array depth of 64 dwords. An offset of 0x200 therefore lands beyond the array and exercises the read-as-zero and dropped-write path, while the primary-bus dword at index 6 stays inside it. This depth keeps the whole local space small enough for the bench's behavioural model to mirror byte by byte. Every lane and size combination of a 32-bit dword is reachable through the offsets the bench chooses.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;
  localparam int CFG_DW = 32;
  localparam int OFF_W  = 10;
  localparam logic [1:0] REG_ADDR = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;
  localparam logic [1:0] REG_ERR  = 2'd3;
  localparam int CTRL_EN   = 31;
  localparam int CTRL_BUSY = 16;
  localparam int CTRL_T1   = 8;
  localparam int CTRL_WR   = 0;
  localparam int ERR_NF    = 0;
  localparam int ERR_ALIGN = 1;
  localparam int ERR_UR    = 4;
  localparam logic [OFF_W-1:0] PRIMARY_DW = 10'd6;

  typedef enum logic [1:0] {TGT_LOCAL, TGT_EXT, TGT_NOTFOUND, TGT_BADALIGN} tgt_e;

  typedef struct packed {
    logic       en;
    logic       t1;
    logic [1:0] sz;
    logic       wr;
  } ctrl_t;

  function automatic logic [CFG_DW-1:0] lane_extract(input logic [CFG_DW-1:0] dw,
                                                      input logic [1:0] lane,
                                                      input logic [1:0] sz);
    logic [CFG_DW-1:0] sh;
    sh = dw >> {lane, 3'b000};
    case (sz)
      2'd0:    return {24'd0, sh[7:0]};
      2'd1:    return {16'd0, sh[15:0]};
      default: return sh;
    endcase
  endfunction
endpackage

// File: rtl/cfgu_decode.sv
module cfgu_decode
  import cfgu_pkg::*;
(
  input  logic [7:0] bus_i,
  input  logic [4:0] dev_i,
  input  logic [1:0] lane_i,
  input  logic [1:0] sz_i,
  input  logic [7:0] root_bus_i,
  input  logic       root_valid_i,
  output tgt_e       tgt_o,
  output logic [3:0] be_o
);
  logic misalign;

  always_comb begin
    misalign = (sz_i == 2'd3) ||
               (sz_i == 2'd1 && lane_i[0]) ||
               (sz_i == 2'd2 && lane_i != 2'd0);
    if (misalign)                tgt_o = TGT_BADALIGN;
    else if (bus_i == root_bus_i) tgt_o = (dev_i == 5'd0) ? TGT_LOCAL : TGT_NOTFOUND;
    else if (!root_valid_i)      tgt_o = TGT_NOTFOUND;
    else                         tgt_o = TGT_EXT;
  end

  always_comb begin
    case (sz_i)
      2'd0:    be_o = 4'b0001 << lane_i;
      2'd1:    be_o = 4'b0011 << lane_i;
      default: be_o = 4'b1111;
    endcase
  end
endmodule

// File: rtl/cfgu_local_space.sv
module cfgu_local_space
  import cfgu_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  idx_i,
  input  logic [3:0]        be_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output logic [CFG_DW-1:0] rdata_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CFG_DW-1:0] mem_q [DEPTH];
  logic              in_range;

  assign in_range = ({22'd0, idx_i} < DEPTH);
  assign rdata_o  = in_range ? mem_q[idx_i[IW-1:0]] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && in_range) begin
      for (int b = 0; b < 4; b++)
        if (be_i[b]) mem_q[idx_i[IW-1:0]][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end
endmodule

// File: rtl/cfgu_req_port.sv
module cfgu_req_port
  import cfgu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [CFG_DW-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [CFG_DW-1:0] wdata_i,
  input  logic              write_i,
  input  logic              type1_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [CFG_DW-1:0] req_addr_o,
  output logic [3:0]        req_be_o,
  output logic [CFG_DW-1:0] req_wdata_o,
  output logic              req_write_o,
  output logic              req_type1_o,
  input  logic              resp_valid_i,
  output logic              busy_o,
  output logic              done_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_e;
  st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      req_addr_o  <= '0;
      req_be_o    <= '0;
      req_wdata_o <= '0;
      req_write_o <= 1'b0;
      req_type1_o <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (launch_i) begin
          st_q        <= ST_REQ;
          req_addr_o  <= {addr_i[31:2], 2'b00};
          req_be_o    <= be_i;
          req_wdata_o <= wdata_i;
          req_write_o <= write_i;
          req_type1_o <= type1_i;
        end
        ST_REQ:  if (req_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (resp_valid_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o = (st_q == ST_REQ);
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_WAIT) && resp_valid_i;

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_be_o)));
  p_req_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |=> !req_valid_o);
endmodule

// File: rtl/cfg_access_unit.sv
module cfg_access_unit
  import cfgu_pkg::*;
#(
  parameter int LCFG_DEPTH = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        req_valid_o,
  input  logic        req_ready_i,
  output logic [31:0] req_addr_o,
  output logic [3:0]  req_be_o,
  output logic [31:0] req_wdata_o,
  output logic        req_write_o,
  output logic        req_type1_o,
  input  logic        resp_valid_i,
  input  logic        resp_ur_i,
  input  logic [31:0] resp_rdata_i
);
  logic [CFG_DW-1:0] addr_q, data_q;
  logic [2:0]        err_q;
  ctrl_t             ctrl_q, ctrl_in;
  logic [7:0]        root_bus_q;
  logic              root_valid_q;
  logic [1:0]        pend_lane_q;
  logic              busy, done, ctrl_wr, launch, loc_we;
  tgt_e              tgt;
  logic [3:0]        be;
  logic [CFG_DW-1:0] placed, loc_rdata, ctrl_rd;
  logic [2:0]        err_set;

  assign ctrl_wr = reg_we_i && (reg_addr_i == REG_CTRL) && !busy;
  assign ctrl_in = '{en: reg_wdata_i[CTRL_EN], t1: reg_wdata_i[CTRL_T1],
                     sz: reg_wdata_i[5:4], wr: reg_wdata_i[CTRL_WR]};
  assign launch  = ctrl_wr && ctrl_in.en;
  assign placed  = data_q << {addr_q[1:0], 3'b000};
  assign loc_we  = launch && (tgt == TGT_LOCAL) && ctrl_in.wr;

  cfgu_decode u_decode (
    .bus_i(addr_q[31:24]), .dev_i(addr_q[23:19]), .lane_i(addr_q[1:0]),
    .sz_i(ctrl_in.sz), .root_bus_i(root_bus_q), .root_valid_i(root_valid_q),
    .tgt_o(tgt), .be_o(be));

  cfgu_local_space #(.DEPTH(LCFG_DEPTH)) u_local (
    .clk_i, .rst_ni, .we_i(loc_we), .idx_i(addr_q[11:2]), .be_i(be),
    .wdata_i(placed), .rdata_o(loc_rdata));

  cfgu_req_port u_port (
    .clk_i, .rst_ni, .launch_i(launch && (tgt == TGT_EXT)), .addr_i(addr_q),
    .be_i(be), .wdata_i(placed), .write_i(ctrl_in.wr), .type1_i(ctrl_in.t1),
    .req_valid_o, .req_ready_i, .req_addr_o, .req_be_o, .req_wdata_o,
    .req_write_o, .req_type1_o, .resp_valid_i, .busy_o(busy), .done_o(done));

  always_comb begin
    err_set = '0;
    if (launch && tgt == TGT_NOTFOUND) err_set[0] = 1'b1;
    if (launch && tgt == TGT_BADALIGN) err_set[1] = 1'b1;
    if (done && resp_ur_i)             err_set[2] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q       <= '0;
      data_q       <= '0;
      err_q        <= '0;
      ctrl_q       <= '0;
      root_bus_q   <= '0;
      root_valid_q <= 1'b0;
      pend_lane_q  <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == REG_ADDR) addr_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == REG_DATA) data_q <= reg_wdata_i;
      if (ctrl_wr) ctrl_q <= ctrl_in;
      if (reg_we_i && reg_addr_i == REG_ERR)
        err_q <= (err_q & ~{reg_wdata_i[ERR_UR], reg_wdata_i[ERR_ALIGN], reg_wdata_i[ERR_NF]})
                 | err_set;
      else
        err_q <= err_q | err_set;
      if (launch && !ctrl_in.wr) begin
        case (tgt)
          TGT_LOCAL: data_q <= lane_extract(loc_rdata, addr_q[1:0], ctrl_in.sz);
          TGT_EXT:   ;
          default:   data_q <= '1;
        endcase
      end
      if (launch && tgt == TGT_EXT) pend_lane_q <= addr_q[1:0];
      if (loc_we && addr_q[11:2] == PRIMARY_DW && be[0]) begin
        root_bus_q   <= placed[7:0];
        root_valid_q <= 1'b1;
      end
      if (done && !ctrl_q.wr)
        data_q <= resp_ur_i ? '1 : lane_extract(resp_rdata_i, pend_lane_q, ctrl_q.sz);
    end
  end

  always_comb begin
    ctrl_rd            = '0;
    ctrl_rd[CTRL_EN]   = ctrl_q.en;
    ctrl_rd[CTRL_BUSY] = busy;
    ctrl_rd[CTRL_T1]   = ctrl_q.t1;
    ctrl_rd[5:4]       = ctrl_q.sz;
    ctrl_rd[CTRL_WR]   = ctrl_q.wr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_rdata_o <= '0;
    else if (reg_re_i) begin
      case (reg_addr_i)
        REG_ADDR: reg_rdata_o <= addr_q;
        REG_CTRL: reg_rdata_o <= ctrl_rd;
        REG_DATA: reg_rdata_o <= data_q;
        default:  reg_rdata_o <= {27'd0, err_q[2], 2'b00, err_q[1], err_q[0]};
      endcase
    end
  end

  p_notfound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && tgt == TGT_NOTFOUND) |=> (err_q[0] && !req_valid_o));
  p_local_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && tgt == TGT_LOCAL) |=> !req_valid_o);
  p_badalign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && tgt == TGT_BADALIGN) |=> (err_q[1] && !req_valid_o));
  p_ur_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && resp_ur_i) |=> err_q[2]);
  p_fail_ones_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && resp_ur_i && !ctrl_q.wr) |=> (data_q == '1));
endmodule

// File: tb/cfg_access_unit_tb.sv
`timescale 1ns/1ps
module cfg_access_unit_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 0, reg_re_i = 0;
  logic [1:0] reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0, reg_rdata_o;
  logic req_valid_o, req_ready_i = 0, req_write_o, req_type1_o;
  logic [31:0] req_addr_o, req_wdata_o;
  logic [3:0] req_be_o;
  logic resp_valid_i = 0, resp_ur_i = 0;
  logic [31:0] resp_rdata_i = 0;

  int tests = 0, fails = 0;
  bit finished = 0, m_ext_ok = 0;
  logic [31:0] m_cfg [0:63];
  logic [7:0] m_root = 0;
  bit m_root_ok = 0;
  logic [31:0] m_err = 0;

  always #4 clk = ~clk;

  cfg_access_unit u_dut (.clk_i(clk), .rst_ni, .reg_we_i, .reg_re_i, .reg_addr_i,
    .reg_wdata_i, .reg_rdata_o, .req_valid_o, .req_ready_i, .req_addr_o, .req_be_o,
    .req_wdata_o, .req_write_o, .req_type1_o, .resp_valid_i, .resp_ur_i, .resp_rdata_i);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_ni && req_valid_o && !m_ext_ok) begin
      fails++;
      $display("FAIL R4/R5 unexpected request act=%h exp=0", req_addr_o);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk); reg_we_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_re_i = 1; reg_addr_i = a;
    @(negedge clk); reg_re_i = 0; d = reg_rdata_o;
  endtask

  function automatic logic [31:0] ext(input logic [31:0] d, input logic [1:0] ln, input logic [1:0] sz);
    logic [31:0] s;
    s = d >> (8 * ln);
    if (sz == 0) return s & 32'hFF;
    if (sz == 1) return s & 32'hFFFF;
    return s;
  endfunction

  task automatic acc(input logic [7:0] bus, input logic [4:0] dev, input logic [2:0] fn,
                     input logic [11:0] off, input logic [1:0] sz, input bit w, input bit t1,
                     input logic [31:0] wd, input logic [31:0] rsp, input bit ur,
                     input bit poke, input string tag);
    logic [31:0] a, r, ctl, bm, pl, exp_d;
    logic [3:0] be;
    logic [1:0] ln;
    int kind, idx;
    a = {bus, dev, fn, 4'h0, off};
    ln = off[1:0];
    idx = off[11:2];
    wr(0, a);
    if (w) wr(2, wd);
    if (sz == 3 || (sz == 1 && ln[0]) || (sz == 2 && ln != 0)) kind = 2;
    else if (bus == m_root) kind = (dev != 0) ? 1 : 0;
    else if (!m_root_ok) kind = 1;
    else kind = 3;
    be = (sz == 0) ? 4'b0001 << ln : (sz == 1) ? 4'b0011 << ln : 4'b1111;
    bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    pl = wd << (8 * ln);
    ctl = 32'h8000_0000; ctl[8] = t1; ctl[5:4] = sz; ctl[0] = w;
    exp_d = wd;
    m_ext_ok = (kind == 3);
    wr(1, ctl);
    if (kind == 3) begin
      chk({tag, " R3 req valid"}, {31'd0, req_valid_o}, 1);
      chk({tag, " R2 req addr"}, req_addr_o, {a[31:2], 2'b00});
      chk({tag, " R7 req be"}, {28'd0, req_be_o}, {28'd0, be});
      chk({tag, " R2 req dir/type"}, {30'd0, req_write_o, req_type1_o}, {30'd0, w, t1});
      if (w) chk({tag, " R7 req wdata"}, req_wdata_o & bm, pl & bm);
      rd(1, r); chk({tag, " R3 busy"}, r, ctl | 32'h0001_0000);
      if (poke) begin
        wr(1, 32'h8000_0111);
        rd(1, r); chk({tag, " R3 ctrl write ignored while busy"}, r, ctl | 32'h0001_0000);
        chk({tag, " R3 req held"}, {31'd0, req_valid_o}, 1);
      end
      req_ready_i = 1; @(negedge clk); req_ready_i = 0;
      chk({tag, " R3 req dropped"}, {31'd0, req_valid_o}, 0);
      resp_valid_i = 1; resp_rdata_i = rsp; resp_ur_i = ur;
      @(negedge clk); resp_valid_i = 0; resp_ur_i = 0;
      m_ext_ok = 0;
      if (ur) m_err |= 32'h10;
      if (!w) exp_d = ur ? 32'hFFFF_FFFF : ext(rsp, ln, sz);
    end else begin
      chk({tag, " R4/R5 no request"}, {31'd0, req_valid_o}, 0);
      if (kind == 0) begin
        if (w) begin
          if (idx < 64)
            for (int b = 0; b < 4; b++) if (be[b]) m_cfg[idx][8*b +: 8] = pl[8*b +: 8];
          if (idx == 6 && be[0]) begin m_root = pl[7:0]; m_root_ok = 1; end
        end else exp_d = (idx < 64) ? ext(m_cfg[idx], ln, sz) : 32'h0;
      end else begin
        m_err |= (kind == 1) ? 32'h1 : 32'h2;
        if (!w) exp_d = 32'hFFFF_FFFF;
      end
    end
    if (!w) begin rd(2, r); chk({tag, " R7/R13 read data"}, r, exp_d); end
    rd(1, r); chk({tag, " R12 ctrl idle readback"}, r, ctl);
    wr(1, 0);
    rd(1, r); chk({tag, " R12 ctrl cleared"}, r, 0);
    rd(3, r); chk({tag, " error flags"}, r, m_err);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 64; i++) m_cfg[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    chk("R1 no request", {31'd0, req_valid_o}, 0);
    for (int i = 0; i < 4; i++) begin rd(i[1:0], r); chk("R1 reset value", r, 0); end
    // R11: rdata holds until the edge after the strobe
    wr(0, 32'h1234_5678);
    @(negedge clk); reg_re_i = 1; reg_addr_i = 0; #1;
    chk("R11 not yet updated", reg_rdata_o, 0);
    @(negedge clk); reg_re_i = 0;
    chk("R11 registered read", reg_rdata_o, 32'h1234_5678);
    // R6: non-root before root bus set
    acc(8'd2, 5'd1, 3'd0, 12'h000, 2, 0, 0, 0, 0, 0, 0, "R6 before root set");
    wr(3, 32'h1); m_err &= ~32'h1;
    rd(3, r); chk("R10 clear", r, m_err);
    acc(8'd0, 5'd3, 3'd0, 12'h000, 2, 0, 0, 0, 0, 0, 0, "R4 root dev3");
    // R5: local path with lanes
    acc(8'd0, 5'd0, 3'd5, 12'h010, 2, 1, 0, 32'h1122_3344, 0, 0, 0, "R5 local word write");
    acc(8'd0, 5'd0, 3'd0, 12'h012, 0, 0, 0, 0, 0, 0, 0, "R5 local byte read");
    acc(8'd0, 5'd0, 3'd0, 12'h012, 1, 0, 0, 0, 0, 0, 0, "R5 local half read");
    acc(8'd0, 5'd0, 3'd0, 12'h013, 0, 1, 0, 32'h0000_00AA, 0, 0, 0, "R7 local byte write");
    acc(8'd0, 5'd0, 3'd0, 12'h010, 2, 0, 0, 0, 0, 0, 0, "R7 local merged read");
    acc(8'd0, 5'd0, 3'd0, 12'h200, 2, 1, 0, 32'hDEAD_BEEF, 0, 0, 0, "R5 out of range write");
    acc(8'd0, 5'd0, 3'd0, 12'h200, 2, 0, 0, 0, 0, 0, 0, "R5 out of range read");
    // R6: primary bus byte moves root bus to 3
    acc(8'd0, 5'd0, 3'd0, 12'h018, 0, 1, 0, 32'h0000_0003, 0, 0, 0, "R6 primary write");
    acc(8'd3, 5'd0, 3'd0, 12'h018, 0, 0, 0, 0, 0, 0, 0, "R6 local at new root");
    acc(8'd3, 5'd1, 3'd0, 12'h000, 2, 0, 0, 0, 0, 0, 0, "R4 new root dev1");
    // External path
    acc(8'd1, 5'd2, 3'd3, 12'h046, 0, 0, 0, 0, 32'hA1B2_C3D4, 0, 1, "R7 ext byte read");
    acc(8'd7, 5'd31, 3'd7, 12'hFFC, 2, 1, 1, 32'hCAFE_F00D, 0, 0, 0, "R2 ext word write type1");
    acc(8'd0, 5'd4, 3'd1, 12'h0A2, 1, 1, 0, 32'h0000_BEEF, 0, 0, 0, "R7 ext half write");
    acc(8'd9, 5'd0, 3'd2, 12'h104, 2, 0, 1, 0, 32'h5555_AAAA, 1, 0, "R9 ext UR read");
    acc(8'd9, 5'd0, 3'd2, 12'h102, 1, 0, 0, 0, 32'h8765_4321, 0, 0, "R7 ext half read");
    // R8: bad alignment and size
    acc(8'd1, 5'd0, 3'd0, 12'h041, 1, 0, 0, 0, 0, 0, 0, "R8 odd half");
    acc(8'd1, 5'd0, 3'd0, 12'h042, 2, 0, 0, 0, 0, 0, 0, "R8 unaligned word");
    acc(8'd1, 5'd0, 3'd0, 12'h040, 3, 0, 0, 0, 0, 0, 0, "R8 size 3");
    // R10: write-one-to-clear per bit
    wr(3, 32'h10); m_err &= ~32'h10;
    rd(3, r); chk("R10 clear UR only", r, m_err);
    wr(3, 32'h0);
    rd(3, r); chk("R10 zero write keeps", r, m_err);
    wr(3, r); m_err = 0;
    rd(3, r); chk("R10 write back clears", r, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule